// File: doc/BRIEF.md
# Raster Timing Generator for a Character-Cell Video Display

This block produces the horizontal and vertical timing of a character-based raster display. A character counter steps once per enabled character clock and wraps at the programmed line length. A raster-line counter steps once per line within a character row, and a row counter steps once per row. After the last row, an optional run of vertical-adjust lines ends the frame. A frame counter steps at every frame restart, and the display logic uses it for field selection and blink.

From these counters the block derives horizontal and vertical sync, a display-enable signal and a video-source select. The select picks black during sync, border outside the active window and pixel data inside it. The block also outputs a linear memory address for the character fetch and a row address for the glyph line. A CPU programs the timing through a two-location port. One location holds the register index and the other carries the data. The screen start address takes effect only at the next frame restart, so software can change it at any point in a frame without tearing the current picture.

Top module: `rtg_top`

## Requirements
- R1: The character counter runs 0 up to the line-total register (index 0) and then returns to 0. All counters and all timing outputs hold their values in any cycle where `char_en` is low.
- R2: `hsync` rises on entry to the character whose count equals the sync-position register (index 2). It stays high for W characters, where W is bits 3..0 of register index 3, and a value of 0 gives W = 16.
- R3: The raster-line counter runs 0 up to register index 9, and the row counter runs 0 up to register index 4. After the last line of the last row, N adjust lines follow, where N is register index 5. During these lines `ra` shows the adjust line number starting at 0. The frame then restarts with all counters at 0. When N = 0 the adjust phase is skipped.
- R4: `vsync` rises at character 0 of raster line 0 of the row equal to register index 7, outside the adjust phase. It stays high for 16 raster lines and is not restarted while it is still running.
- R5: `disp_en` is high only when the character count is below register index 1, the row count is below register index 6 and the adjust phase is not running. With register index 6 equal to 0, `disp_en` stays low for the whole frame.
- R6: `ma` equals start + row·(index 1) + character, taken modulo 2^14. The start value comes from the registers at index 12 (bits 13..8, from data bits 5..0) and index 13 (bits 7..0). It is copied only at a frame restart, so a write to these registers has no effect on `ma` until then.
- R7: `vid_sel` encodes the video source: 2 whenever `hsync` or `vsync` is high, else 1 when `disp_en` is low, else 0.
- R8: `frame_cnt` increments by one at every frame restart and wraps at its width.
- R9: Writes to register index 31 are ignored, and reads of index 31 return 0xFF.
- R10: A write with `cpu_addr` = 0 loads the register index from data bits 4..0, and a write with `cpu_addr` = 1 writes the selected register. Reads with `cpu_addr` = 1 return the start registers at indices 12 and 13, and return 0 for every other write-only index. Reads with `cpu_addr` = 0 return 0.
- R11: After reset all registers and counters are 0, both syncs are low, `disp_en` is low, `vid_sel` is 1, and `ma`, `ra` and `frame_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | Character clock enable |
| cpu_cs | input | 1 | CPU port select |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 = index location, 1 = data location |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Active display window |
| vid_sel | output | 2 | Video source: 0 pixel, 1 border, 2 black |
| ma | output | 14 | Character memory address |
| ra | output | 5 | Raster line within the row, or adjust line |
| frame_cnt | output | 4 | Frame counter |

## Verification
A wrong character count appears in `ma` on the very next enabled character. A wrong raster-line or adjust count appears in `ra` at the next line boundary. A row counter that slips shows up in `ma` and `disp_en` within one line, and it shifts the `vsync` edge by whole rows. A wrong start latch appears only after the next frame restart, so the start address is checked across frame boundaries. The sync down-counters are checked by comparing the edges and the length of every pulse against a behavioural model on every clock. An error in either counter shows up one character or one line after the faulty edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int DW   = 8;
  localparam int IDXW = 5;
  localparam int HCW  = 8;
  localparam int RCW  = 7;
  localparam int LCW  = 5;
  localparam int SWW  = 4;
  localparam int MAW  = 14;

  localparam logic [IDXW-1:0] IX_HTOT     = 5'd0;
  localparam logic [IDXW-1:0] IX_HDISP    = 5'd1;
  localparam logic [IDXW-1:0] IX_HSPOS    = 5'd2;
  localparam logic [IDXW-1:0] IX_SWID     = 5'd3;
  localparam logic [IDXW-1:0] IX_VTOT     = 5'd4;
  localparam logic [IDXW-1:0] IX_VADJ     = 5'd5;
  localparam logic [IDXW-1:0] IX_VDISP    = 5'd6;
  localparam logic [IDXW-1:0] IX_VSPOS    = 5'd7;
  localparam logic [IDXW-1:0] IX_LMAX     = 5'd9;
  localparam logic [IDXW-1:0] IX_START_HI = 5'd12;
  localparam logic [IDXW-1:0] IX_START_LO = 5'd13;
  localparam logic [IDXW-1:0] IX_DUMMY    = 5'd31;

  typedef enum logic [1:0] {
    VS_PIXEL  = 2'd0,
    VS_BORDER = 2'd1,
    VS_BLACK  = 2'd2
  } vsel_e;

  typedef struct packed {
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hdisp;
    logic [HCW-1:0] hspos;
    logic [SWW-1:0] swid;
    logic [RCW-1:0] vtot;
    logic [LCW-1:0] vadj;
    logic [RCW-1:0] vdisp;
    logic [RCW-1:0] vspos;
    logic [LCW-1:0] lmax;
    logic [MAW-1:0] start;
  } cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_cs,
  input  logic            cpu_we,
  input  logic            cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output cfg_t            cfg,
  output logic [IDXW-1:0] sel_idx,
  output logic [DW-1:0]   cpu_rdata
);
  cfg_t            cfg_q, cfg_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            wr_en;

  assign wr_en = cpu_cs & cpu_we;

  always_comb begin
    cfg_d = cfg_q;
    idx_d = idx_q;
    if (!cpu_addr) begin
      idx_d = cpu_wdata[IDXW-1:0];
    end else begin
      case (idx_q)
        IX_HTOT:     cfg_d.htot  = cpu_wdata[HCW-1:0];
        IX_HDISP:    cfg_d.hdisp = cpu_wdata[HCW-1:0];
        IX_HSPOS:    cfg_d.hspos = cpu_wdata[HCW-1:0];
        IX_SWID:     cfg_d.swid  = cpu_wdata[SWW-1:0];
        IX_VTOT:     cfg_d.vtot  = cpu_wdata[RCW-1:0];
        IX_VADJ:     cfg_d.vadj  = cpu_wdata[LCW-1:0];
        IX_VDISP:    cfg_d.vdisp = cpu_wdata[RCW-1:0];
        IX_VSPOS:    cfg_d.vspos = cpu_wdata[RCW-1:0];
        IX_LMAX:     cfg_d.lmax  = cpu_wdata[LCW-1:0];
        IX_START_HI: cfg_d.start[MAW-1:DW] = cpu_wdata[MAW-DW-1:0];
        IX_START_LO: cfg_d.start[DW-1:0]   = cpu_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      idx_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr) begin
      case (idx_q)
        IX_START_HI: cpu_rdata = DW'(cfg_q.start[MAW-1:DW]);
        IX_START_LO: cpu_rdata = cfg_q.start[DW-1:0];
        IX_DUMMY:    cpu_rdata = '1;
        default:     cpu_rdata = '0;
      endcase
    end
  end

  assign cfg     = cfg_q;
  assign sel_idx = idx_q;
endmodule

// File: rtl/rtg_hctl.sv
module rtg_hctl #(
  parameter int HCW = rtg_pkg::HCW,
  parameter int SWW = rtg_pkg::SWW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           char_en,
  input  logic [HCW-1:0] htot,
  input  logic [HCW-1:0] hspos,
  input  logic [SWW-1:0] swid,
  output logic [HCW-1:0] c0,
  output logic           line_end,
  output logic           hsync
);
  localparam int HSC = SWW + 1;
  localparam logic [HSC-1:0] HS_FULL = HSC'(1 << SWW);
  localparam logic [HSC-1:0] HS_ONE  = HSC'(1);

  logic [HCW-1:0] c0_q, c0_d, c0_nxt;
  logic [HSC-1:0] hs_q, hs_d, hs_width;

  assign line_end = (c0_q == htot);
  assign c0_nxt   = line_end ? '0 : c0_q + 1'b1;
  assign hs_width = (swid == '0) ? HS_FULL : {1'b0, swid};

  always_comb begin
    c0_d = c0_q;
    hs_d = hs_q;
    if (char_en) begin
      c0_d = c0_nxt;
      if ((c0_nxt == hspos) && (hs_q <= HS_ONE)) begin
        hs_d = hs_width;
      end else if (hs_q != '0) begin
        hs_d = hs_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      hs_q <= '0;
    end else if (char_en) begin
      c0_q <= c0_d;
      hs_q <= hs_d;
    end
  end

  assign c0    = c0_q;
  assign hsync = (hs_q != '0);
endmodule

// File: rtl/rtg_vctl.sv
module rtg_vctl #(
  parameter int HCW = rtg_pkg::HCW,
  parameter int RCW = rtg_pkg::RCW,
  parameter int LCW = rtg_pkg::LCW,
  parameter int MAW = rtg_pkg::MAW,
  parameter int FCW = 4,
  parameter int VSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_adv,
  input  logic [LCW-1:0] lmax,
  input  logic [RCW-1:0] vtot,
  input  logic [LCW-1:0] vadj,
  input  logic [RCW-1:0] vspos,
  input  logic [HCW-1:0] hdisp,
  input  logic [MAW-1:0] start,
  output logic [LCW-1:0] c9,
  output logic [RCW-1:0] c4,
  output logic           in_adj,
  output logic [LCW-1:0] adj_cnt,
  output logic           vsync,
  output logic [FCW-1:0] frame_cnt,
  output logic [MAW-1:0] row_addr
);
  localparam int VSC = $clog2(VSW + 1);
  localparam logic [VSC-1:0] VS_LEN = VSC'(VSW);
  localparam logic [VSC-1:0] VS_ONE = VSC'(1);

  logic [LCW-1:0] c9_q, c9_d, adjc_q, adjc_d;
  logic [RCW-1:0] c4_q, c4_d;
  logic           adj_q, adj_d, restart;
  logic [VSC-1:0] vs_q, vs_d;
  logic [FCW-1:0] fc_q, fc_d;
  logic [MAW-1:0] row_q, row_d;
  logic [LCW:0]   adjc_inc;

  assign adjc_inc = {1'b0, adjc_q} + {{LCW{1'b0}}, 1'b1};

  always_comb begin
    c9_d    = c9_q;
    c4_d    = c4_q;
    adj_d   = adj_q;
    adjc_d  = adjc_q;
    vs_d    = vs_q;
    fc_d    = fc_q;
    row_d   = row_q;
    restart = 1'b0;
    if (line_adv) begin
      if (!adj_q) begin
        if (c9_q == lmax) begin
          c9_d = '0;
          if (c4_q == vtot) begin
            if (vadj == '0) begin
              restart = 1'b1;
            end else begin
              adj_d  = 1'b1;
              adjc_d = '0;
            end
          end else begin
            c4_d  = c4_q + 1'b1;
            row_d = row_q + MAW'(hdisp);
          end
        end else begin
          c9_d = c9_q + 1'b1;
        end
      end else if (adjc_inc == {1'b0, vadj}) begin
        restart = 1'b1;
      end else begin
        adjc_d = adjc_q + 1'b1;
      end
      if (restart) begin
        c9_d   = '0;
        c4_d   = '0;
        adj_d  = 1'b0;
        adjc_d = '0;
        fc_d   = fc_q + 1'b1;
        row_d  = start;
      end
      if (!adj_d && (c9_d == '0) && (c4_d == vspos) && (vs_q <= VS_ONE)) begin
        vs_d = VS_LEN;
      end else if (vs_q != '0) begin
        vs_d = vs_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c9_q   <= '0;
      c4_q   <= '0;
      adj_q  <= 1'b0;
      adjc_q <= '0;
      vs_q   <= '0;
      fc_q   <= '0;
      row_q  <= '0;
    end else if (line_adv) begin
      c9_q   <= c9_d;
      c4_q   <= c4_d;
      adj_q  <= adj_d;
      adjc_q <= adjc_d;
      vs_q   <= vs_d;
      fc_q   <= fc_d;
      row_q  <= row_d;
    end
  end

  assign c9        = c9_q;
  assign c4        = c4_q;
  assign in_adj    = adj_q;
  assign adj_cnt   = adjc_q;
  assign vsync     = (vs_q != '0);
  assign frame_cnt = fc_q;
  assign row_addr  = row_q;
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int FCW         = 4,
  parameter int VSYNC_LINES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           char_en,
  input  logic           cpu_cs,
  input  logic           cpu_we,
  input  logic           cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           hsync,
  output logic           vsync,
  output logic           disp_en,
  output logic [1:0]     vid_sel,
  output logic [MAW-1:0] ma,
  output logic [LCW-1:0] ra,
  output logic [FCW-1:0] frame_cnt
);
  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  cfg_t            cfg;
  logic [IDXW-1:0] sel_idx;
  logic [HCW-1:0]  c0;
  logic [LCW-1:0]  c9, adj_cnt;
  logic [RCW-1:0]  c4;
  logic            in_adj, line_end, line_adv;
  logic [MAW-1:0]  row_addr;
  vsel_e           vsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cfg(cfg),
    .sel_idx(sel_idx), .cpu_rdata(cpu_rdata)
  );

  rtg_hctl #(.HCW(HCW), .SWW(SWW)) u_hctl (
    .clk(clk), .rst_n(rst_int_n), .char_en(char_en), .htot(cfg.htot),
    .hspos(cfg.hspos), .swid(cfg.swid), .c0(c0), .line_end(line_end),
    .hsync(hsync)
  );

  assign line_adv = char_en & line_end;

  rtg_vctl #(.HCW(HCW), .RCW(RCW), .LCW(LCW), .MAW(MAW), .FCW(FCW),
             .VSW(VSYNC_LINES)) u_vctl (
    .clk(clk), .rst_n(rst_int_n), .line_adv(line_adv), .lmax(cfg.lmax),
    .vtot(cfg.vtot), .vadj(cfg.vadj), .vspos(cfg.vspos), .hdisp(cfg.hdisp),
    .start(cfg.start), .c9(c9), .c4(c4), .in_adj(in_adj), .adj_cnt(adj_cnt),
    .vsync(vsync), .frame_cnt(frame_cnt), .row_addr(row_addr)
  );

  assign disp_en = (c0 < cfg.hdisp) && (c4 < cfg.vdisp) && !in_adj;
  assign ma      = row_addr + MAW'(c0);
  assign ra      = in_adj ? adj_cnt : c9;

  always_comb begin
    if (hsync || vsync) vsel = VS_BLACK;
    else if (!disp_en)  vsel = VS_BORDER;
    else                vsel = VS_PIXEL;
  end
  assign vid_sel = vsel;
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int FCW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            char_en,
  input logic            hsync,
  input logic            vsync,
  input logic            disp_en,
  input logic [1:0]      vid_sel,
  input logic [FCW-1:0]  frame_cnt,
  input logic [HCW-1:0]  c0,
  input logic [LCW-1:0]  c9,
  input logic [RCW-1:0]  c4,
  input logic            in_adj,
  input cfg_t            cfg,
  input logic            cpu_addr,
  input logic [IDXW-1:0] sel_idx,
  input logic [DW-1:0]   cpu_rdata
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> $stable(c0) && $stable(c9) && $stable(c4));

  a_r2_hsync_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (c0 == cfg.hspos));

  a_r4_vsync_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (c0 == '0) && (c9 == '0) && !in_adj && (c4 == cfg.vspos));

  a_r5_rows0_border: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.vdisp == '0) |-> !disp_en);

  a_r7_black: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> (vid_sel == VS_BLACK));

  a_r7_border: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !vsync && !disp_en) |-> (vid_sel == VS_BORDER));

  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt != $past(frame_cnt)) |-> (c0 == '0) && (c9 == '0) && (c4 == '0) && !in_adj);

  a_r9_dummy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr && (sel_idx == IX_DUMMY)) |-> (cpu_rdata == 8'hFF));
endmodule

bind rtg_top rtg_chk #(.FCW(FCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_en(char_en), .hsync(hsync), .vsync(vsync),
  .disp_en(disp_en), .vid_sel(vid_sel), .frame_cnt(frame_cnt), .c0(c0),
  .c9(c9), .c4(c4), .in_adj(in_adj), .cfg(cfg), .cpu_addr(cpu_addr),
  .sel_idx(sel_idx), .cpu_rdata(cpu_rdata)
);

// File: tb/tb_rtg_top.sv
module tb_rtg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_en = 1'b0;
  logic       cpu_cs = 1'b0, cpu_we = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       hsync, vsync, disp_en;
  logic [1:0] vid_sel;
  logic [13:0] ma;
  logic [4:0] ra;
  logic [3:0] frame_cnt;

  int checks = 0, errors = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtg_top dut (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .cpu_cs(cpu_cs),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .vid_sel(vid_sel), .ma(ma), .ra(ra), .frame_cnt(frame_cnt)
  );

  // Behavioural reference model
  int rg[32];
  int m_idx, m_c0, m_c9, m_c4, m_adj, m_adjc, m_hl, m_vl, m_fc, m_start;

  function automatic int wmask(int i);
    case (i)
      0, 1, 2, 13: return 255;
      3:           return 15;
      4, 6, 7:     return 127;
      5, 9:        return 31;
      12:          return 63;
      default:     return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) rg[k] = 0;
      m_idx = 0; m_c0 = 0; m_c9 = 0; m_c4 = 0; m_adj = 0; m_adjc = 0;
      m_hl = 0; m_vl = 0; m_fc = 0; m_start = 0;
    end else begin
      if (char_en) begin
        int w, nc0;
        bit lend, rs;
        lend = (m_c0 == rg[0]);
        nc0  = lend ? 0 : (m_c0 + 1) % 256;
        w    = (rg[3] == 0) ? 16 : rg[3];
        if (nc0 == rg[2] && m_hl <= 1) m_hl = w;
        else if (m_hl > 0) m_hl--;
        if (lend) begin
          rs = 0;
          if (!m_adj) begin
            if (m_c9 == rg[9]) begin
              m_c9 = 0;
              if (m_c4 == rg[4]) begin
                if (rg[5] == 0) rs = 1;
                else begin m_adj = 1; m_adjc = 0; end
              end else m_c4 = m_c4 + 1;
            end else m_c9 = m_c9 + 1;
          end else if (m_adjc + 1 == rg[5]) rs = 1;
          else m_adjc = m_adjc + 1;
          if (rs) begin
            m_c9 = 0; m_c4 = 0; m_adj = 0; m_adjc = 0;
            m_fc = (m_fc + 1) % 16;
            m_start = rg[12] * 256 + rg[13];
          end
          if (!m_adj && m_c9 == 0 && m_c4 == rg[7] && m_vl <= 1) m_vl = 16;
          else if (m_vl > 0) m_vl--;
        end
        m_c0 = nc0;
      end
      if (cpu_cs && cpu_we) begin
        if (!cpu_addr) m_idx = cpu_wdata & 31;
        else rg[m_idx] = cpu_wdata & wmask(m_idx);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int e_de, e_vs, e_rd;
      e_de = (m_c0 < rg[1]) && (m_c4 < rg[6]) && !m_adj;
      e_vs = (m_hl > 0 || m_vl > 0) ? 2 : (!e_de ? 1 : 0);
      e_rd = 0;
      if (cpu_addr) e_rd = (m_idx == 12) ? rg[12] : (m_idx == 13) ? rg[13] : (m_idx == 31) ? 255 : 0;
      chk("R2", "hsync", int'(hsync), int'(m_hl > 0));
      chk("R4", "vsync", int'(vsync), int'(m_vl > 0));
      chk("R5", "disp_en", int'(disp_en), e_de);
      chk("R7", "vid_sel", int'(vid_sel), e_vs);
      chk("R1/R6", "ma", int'(ma), (m_start + m_c4 * rg[1] + m_c0) % 16384);
      chk("R3", "ra", int'(ra), m_adj ? m_adjc : m_c9);
      chk("R8", "frame_cnt", int'(frame_cnt), m_fc);
      chk((cpu_addr && m_idx == 31) ? "R9" : "R10", "cpu_rdata", int'(cpu_rdata), e_rd);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(bit a, int d);
    tick();
    cpu_cs = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = 8'(d);
    tick();
    cpu_cs = 0; cpu_we = 0;
  endtask

  task automatic setreg(int i, int d);
    wr(0, i); wr(1, d);
  endtask

  task automatic do_reset();
    tick();
    cmp_en = 0; rst_n = 0; char_en = 0; cpu_addr = 0;
    repeat (2) tick();
    rst_n = 1;
    repeat (4) tick();
    cmp_en = 1;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      tick();
      char_en = (mode == 0) ? 1'b1 : ((i % 3) != 0);
    end
    tick();
    char_en = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk("R11", "hsync", int'(hsync), 0);
    chk("R11", "vsync", int'(vsync), 0);
    chk("R11", "disp_en", int'(disp_en), 0);
    chk("R11", "vid_sel", int'(vid_sel), 1);
    chk("R11", "ma", int'(ma), 0);
    chk("R11", "ra", int'(ra), 0);
    chk("R11", "frame_cnt", int'(frame_cnt), 0);

    // Config A: adjust lines, 3-wide hsync
    setreg(0, 15); setreg(1, 10); setreg(2, 11); setreg(3, 3);
    setreg(4, 5);  setreg(5, 2);  setreg(6, 4);  setreg(7, 2); setreg(9, 3);
    run(1200, 0);

    // R1: outputs hold while char_en is low
    begin
      int ma0, ra0;
      @(negedge clk); ma0 = ma; ra0 = ra;
      repeat (5) @(negedge clk);
      chk("R1", "ma hold", int'(ma), ma0);
      chk("R1", "ra hold", int'(ra), ra0);
    end

    // Config B: zero width means 16, zero displayed rows, gated enable, counter wrap
    do_reset();
    setreg(0, 31); setreg(1, 20); setreg(2, 8); setreg(3, 0);
    setreg(4, 3);  setreg(5, 0);  setreg(6, 0); setreg(7, 0); setreg(9, 1);
    run(7000, 1);

    // Config C: start address sampling with wrap, vsync longer than frame
    do_reset();
    setreg(0, 9); setreg(1, 8); setreg(2, 2); setreg(3, 5);
    setreg(4, 2); setreg(5, 3); setreg(6, 2); setreg(7, 1); setreg(9, 1);
    setreg(12, 8'h3F); setreg(13, 8'hF8);
    run(150, 0);
    begin
      int ma0;
      @(negedge clk); ma0 = ma;
      setreg(12, 8'h05); setreg(13, 8'h40);
      @(negedge clk);
      chk("R6", "ma unchanged after start write", int'(ma), ma0);
    end
    run(400, 1);

    // R9 / R10: dummy register and readback
    wr(0, 31); wr(1, 8'h5A);
    tick(); cpu_addr = 1;
    @(negedge clk);
    chk("R9", "dummy read", int'(cpu_rdata), 255);
    tick(); cpu_addr = 0;
    wr(0, 12);
    tick(); cpu_addr = 1;
    @(negedge clk);
    chk("R10", "start hi readback", int'(cpu_rdata), 5);
    wr(0, 0);
    tick(); cpu_addr = 1;
    @(negedge clk);
    chk("R10", "write-only reads 0", int'(cpu_rdata), 0);
    tick(); cpu_addr = 0;
    @(negedge clk);
    chk("R10", "index location reads 0", int'(cpu_rdata), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule